// File: doc/BRIEF.md
# Zero-turnaround pipelined SRAM

This block is a synthesizable model of a synchronous SRAM with a 72-bit word, built for simulation with a small parameterized depth. Commands are sampled on the rising clock. The block returns read data two edges after a read command. It samples write data two edges after a write command. Because both sides of the bus use the same latency, reads and writes can alternate on consecutive cycles without idle turnaround cycles.

A write is not applied to the array when its data arrives. It first passes through two pending-write registers and is committed to the array after that. While a write is still pending, a read of the same address is served per byte lane from the newest pending data. A new command starts on a load cycle. On continuation cycles, an internal burst counter steps the two low address bits in either linear or interleaved order. Three chip enables select the device, and two of them have a programmable active level.

Top module: `zt_sram`

## Requirements
- R1: During reset and after its release, `rvalid_o` is low until a read command has completed its two-edge latency. Array contents are not defined by reset.
- R2: A command is accepted only on an edge where `adv_i` is low. The device is selected when `ce_ni` is low, `ce2_i` equals `pol2_i` and `ce3_i` equals `pol3_i`. Any other combination is a deselect.
- R3: For a read command sampled at edge N, `rdata_o` holds the word and `rvalid_o` is high after edge N+2.
- R4: `wr_n_i` low selects write and high selects read. For a write sampled at edge N, `wdata_i` is sampled at edge N+2. Lane k is bits [9k+8:9k], and it is written only when `be_ni[k]` is low.
- R5: On an edge with `adv_i` high, the next beat of the current burst is issued. It keeps the read/write type and byte enables of the load cycle, and only address bits [1:0] change.
- R6: With `burst_mode_i` low (linear), beat c has low address bits equal to (start + c) mod 4.
- R7: With `burst_mode_i` high (interleaved), beat c has low address bits equal to start XOR c.
- R8: A burst wraps after four beats, so a fifth beat returns to the start address.
- R9: A read returns the newest data for each lane, including writes that are still pending. When two pending writes target the same address, the younger one wins for each lane it enables.
- R10: A deselect, or any continuation of a deselect, does no array access and leaves `rvalid_o` low in the matching output slot.
- R11: Read and write commands may alternate on every cycle with no idle cycle, and every read still returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Low: load a new command; high: continue the burst |
| wr_n_i | input | 1 | Low: write; high: read |
| be_ni | input | 8 | Active-low byte-lane write enables |
| ce_ni | input | 1 | Active-low chip enable |
| ce2_i | input | 1 | Chip enable with programmable level |
| ce3_i | input | 1 | Chip enable with programmable level |
| pol2_i | input | 1 | Active level of `ce2_i` |
| pol3_i | input | 1 | Active level of `ce3_i` |
| burst_mode_i | input | 1 | 0: linear burst; 1: interleaved burst |
| addr_i | input | ADDR_W | Word address, used on load cycles |
| wdata_i | input | 72 | Write data, sampled two edges after a write command |
| rdata_o | output | 72 | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The assertions check on every cycle the stage-to-output relation of the valid flag, how deselects and deselect continuations are dropped, that continuations inherit the command type and keep the high address bits, and the linear step of the low address bits. Data correctness is covered by the bench scenarios. These include interleaved ordering, the wrap after four beats, per-lane masking, forwarding from both pending-write stages with the younger write taking priority, and dense random read/write alternation over a tiny address space. Each of these is compared against a behavioural model.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // low address bits for burst beat cnt
  function automatic logic [1:0] burst_lo(input logic [1:0] start, input logic [1:0] cnt,
                                          input logic ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              wr_n_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_no
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;
  op_e               op_q, load_op;
  logic [LANES-1:0]  be_q;

  assign cnt_nx  = cnt_q + 2'd1;
  assign load_op = !sel_i ? OP_NOP : (wr_n_i ? OP_RD : OP_WR);

  always_comb begin
    if (adv_i) begin
      op_o   = op_q;
      be_no  = be_q;
      addr_o = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_nx, mode_i)};
    end else begin
      op_o   = load_op;
      be_no  = be_ni;
      addr_o = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      be_q   <= '1;
    end else if (!adv_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
      op_q   <= load_op;
      be_q   <= be_ni;
    end else begin
      cnt_q  <= cnt_nx;
    end
  end

endmodule

// File: rtl/zt_wr_pipe.sv
module zt_wr_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [LANES-1:0]  push_be_ni,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  // stage a: newest pending write, stage b: next to commit
  logic              pa_v, pb_v;
  logic [ADDR_W-1:0] pa_addr, pb_addr;
  logic [LANES-1:0]  pa_be_n, pb_be_n;
  logic [DATA_W-1:0] pa_data, pb_data;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_v <= 1'b0;
      pb_v <= 1'b0;
    end else begin
      pa_v <= push_i;
      pb_v <= pa_v;
    end
  end

  always_ff @(posedge clk_i) begin
    pa_addr <= push_addr_i;
    pa_be_n <= push_be_ni;
    pa_data <= push_data_i;
    pb_addr <= pa_addr;
    pb_be_n <= pa_be_n;
    pb_data <= pa_data;
  end

  always_ff @(posedge clk_i) begin
    if (pb_v) begin
      for (int k = 0; k < LANES; k++) begin
        if (!pb_be_n[k]) mem_q[pb_addr][k*LANE_W +: LANE_W] <= pb_data[k*LANE_W +: LANE_W];
      end
    end
  end

  // per-lane forwarding, younger stage first
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit_a, hit_b;
    assign hit_a = pa_v && (pa_addr == rd_addr_i) && !pa_be_n[k];
    assign hit_b = pb_v && (pb_addr == rd_addr_i) && !pb_be_n[k];
    assign rd_data_o[k*LANE_W +: LANE_W] =
      hit_a ? pa_data[k*LANE_W +: LANE_W] :
      hit_b ? pb_data[k*LANE_W +: LANE_W] :
              mem_q[rd_addr_i][k*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              wr_n_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic              ce_ni,
  input  logic              ce2_i,
  input  logic              ce3_i,
  input  logic              pol2_i,
  input  logic              pol3_i,
  input  logic              burst_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic              sel;
  op_e               iss_op, s1_op, s2_op;
  logic [ADDR_W-1:0] iss_addr, s1_addr, s2_addr;
  logic [LANES-1:0]  iss_be_n, s1_be_n, s2_be_n;
  logic [DATA_W-1:0] fwd_data;

  assign sel = !ce_ni && (ce2_i == pol2_i) && (ce3_i == pol3_i);

  zt_burst_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv_i),
    .sel_i  (sel),
    .wr_n_i (wr_n_i),
    .be_ni  (be_ni),
    .addr_i (addr_i),
    .mode_i (burst_mode_i),
    .op_o   (iss_op),
    .addr_o (iss_addr),
    .be_no  (iss_be_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op    <= OP_NOP;
      s2_op    <= OP_NOP;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s1_be_n  <= '1;
      s2_be_n  <= '1;
      rvalid_o <= 1'b0;
    end else begin
      s1_op    <= iss_op;
      s1_addr  <= iss_addr;
      s1_be_n  <= iss_be_n;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_be_n  <= s1_be_n;
      rvalid_o <= (s2_op == OP_RD);
    end
  end

  zt_wr_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (s2_op == OP_WR),
    .push_addr_i (s2_addr),
    .push_be_ni  (s2_be_n),
    .push_data_i (wdata_i),
    .rd_addr_i   (s2_addr),
    .rd_data_o   (fwd_data)
  );

  always_ff @(posedge clk_i) begin
    if (s2_op == OP_RD) rdata_o <= fwd_data;
  end

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv_i,
  input logic              ce_ni,
  input logic              burst_mode_i,
  input op_e               s1_op,
  input logic [ADDR_W-1:0] s1_addr,
  input op_e               s2_op,
  input logic              rvalid_o
);

  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_op == OP_RD) |=> rvalid_o);  // R3

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_op != OP_RD) |=> !rvalid_o);  // R10

  AST_DESELECT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && ce_ni) |=> (s1_op == OP_NOP));  // R2

  AST_DESEL_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && s1_op == OP_NOP) |=> (s1_op == OP_NOP));  // R10

  AST_CONT_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && s1_op != OP_NOP) |=> (s1_op == $past(s1_op)));  // R5

  AST_CONT_HI_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && s1_op != OP_NOP) |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));  // R5

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !burst_mode_i && s1_op != OP_NOP) |=>
      (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));  // R6

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adv_i        (adv_i),
  .ce_ni        (ce_ni),
  .burst_mode_i (burst_mode_i),
  .s1_op        (s1_op),
  .s1_addr      (s1_addr),
  .s2_op        (s2_op),
  .rvalid_o     (rvalid_o)
);

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 72;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          adv_i = 1'b0, wr_n_i = 1'b1;
  logic [7:0]    be_ni = 8'hFF;
  logic          ce_ni = 1'b1, ce2_i = 1'b1, ce3_i = 1'b0;
  logic          pol2_i = 1'b1, pol3_i = 1'b0, burst_mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int    checks = 0, errors = 0;
  string cur_tag = "R3 R1";

  always #2 clk_i = ~clk_i;

  zt_sram dut_i (.*);

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] mmem [DEPTH];
  int            q_op[$], q_a[$];
  logic [7:0]    q_be[$];
  int            m_base = 0, m_cnt = 0, m_op = 0;
  logic [7:0]    m_be = 8'hFF;
  logic          exp_valid = 1'b0;
  logic [DW-1:0] exp_data = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_op.delete(); q_a.delete(); q_be.delete();
      m_op = 0; m_cnt = 0; exp_valid = 1'b0;
    end else begin
      int a, lo, op;
      logic [7:0] be;
      logic sel;
      sel = !ce_ni && (ce2_i == pol2_i) && (ce3_i == pol3_i);
      if (!adv_i) begin
        m_base = int'(addr_i); m_cnt = 0; m_be = be_ni;
        m_op = !sel ? 0 : (wr_n_i ? 1 : 2);
        a = m_base;
      end else begin
        m_cnt = (m_cnt + 1) % 4;
        lo = burst_mode_i ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4);
        a = m_base - (m_base % 4) + lo;
      end
      q_op.push_back(m_op); q_a.push_back(a); q_be.push_back(m_be);
      exp_valid = 1'b0;
      if (q_op.size() > 2) begin
        op = q_op.pop_front(); a = q_a.pop_front(); be = q_be.pop_front();
        if (op == 2) begin
          for (int k = 0; k < 8; k++)
            if (!be[k]) mmem[a][k*9 +: 9] = wdata_i[k*9 +: 9];
        end else if (op == 1) begin
          exp_valid = 1'b1;
          exp_data  = mmem[a];
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (rvalid_o !== exp_valid) begin
        errors++;
        $display("FAIL %s (R3 R10 valid): rvalid_o=%0b expected %0b", cur_tag, rvalid_o, exp_valid);
      end
      if (exp_valid) begin
        checks++;
        if (rdata_o !== exp_data) begin
          errors++;
          $display("FAIL %s (data): rdata_o=%h expected %h", cur_tag, rdata_o, exp_data);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input logic adv, input logic wr_n, input logic [7:0] be_n,
                     input logic [AW-1:0] addr);
    adv_i = adv; wr_n_i = wr_n; be_ni = be_n; addr_i = addr;
    wdata_i = {$urandom(), $urandom(), $urandom()};
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      ce_ni = 1'b1; cyc(1'b0, 1'b1, 8'hFF, '0);
    end
    ce_ni = 1'b0;
  endtask

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    checks++;  // R1 valid low under reset
    if (rvalid_o !== 1'b0) begin
      errors++; $display("FAIL R1: rvalid_o=%0b expected 0", rvalid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    ce_ni = 1'b0;

    cur_tag = "R5 R6 fill bursts";
    for (int b = 0; b < DEPTH / 4; b++) begin
      cyc(1'b0, 1'b0, 8'h00, AW'(b * 4));
      for (int j = 0; j < 3; j++) cyc(1'b1, 1'b0, 8'h00, '0);
    end
    idle(3);

    cur_tag = "R8 R6 linear wrap";
    cyc(1'b0, 1'b1, 8'hFF, AW'(10));
    for (int j = 0; j < 4; j++) cyc(1'b1, 1'b1, 8'hFF, '0);
    idle(3);

    cur_tag = "R7 interleaved";
    burst_mode_i = 1'b1;
    cyc(1'b0, 1'b1, 8'hFF, AW'(13));
    for (int j = 0; j < 4; j++) cyc(1'b1, 1'b1, 8'hFF, '0);
    burst_mode_i = 1'b0;
    idle(3);

    cur_tag = "R4 lane mask";
    cyc(1'b0, 1'b0, 8'b1010_0101, AW'(20));
    idle(4);
    cyc(1'b0, 1'b1, 8'hFF, AW'(20));
    idle(3);

    cur_tag = "R9 R11 alternating";
    cyc(1'b0, 1'b0, 8'hF0, AW'(30));
    cyc(1'b0, 1'b1, 8'hFF, AW'(30));
    cyc(1'b0, 1'b0, 8'h0F, AW'(30));
    cyc(1'b0, 1'b1, 8'hFF, AW'(30));
    cyc(1'b0, 1'b1, 8'hFF, AW'(30));
    cyc(1'b0, 1'b0, 8'h00, AW'(31));
    cyc(1'b0, 1'b1, 8'hFF, AW'(31));
    idle(3);

    cur_tag = "R9 younger wins";
    cyc(1'b0, 1'b0, 8'h00, AW'(40));
    cyc(1'b0, 1'b0, 8'hF0, AW'(40));
    cyc(1'b0, 1'b1, 8'hFF, AW'(40));
    cyc(1'b0, 1'b1, 8'hFF, AW'(40));
    cyc(1'b0, 1'b1, 8'hFF, AW'(40));
    idle(3);

    cur_tag = "R10 R2 deselect";
    ce_ni = 1'b1;
    cyc(1'b0, 1'b0, 8'h00, AW'(44));
    cyc(1'b1, 1'b0, 8'h00, '0);
    cyc(1'b1, 1'b0, 8'h00, '0);
    ce_ni = 1'b0; ce2_i = 1'b0;
    cyc(1'b0, 1'b1, 8'hFF, AW'(44));
    cyc(1'b1, 1'b1, 8'hFF, '0);
    pol2_i = 1'b0;
    cyc(1'b0, 1'b1, 8'hFF, AW'(44));
    ce3_i = 1'b1;
    cyc(1'b0, 1'b1, 8'hFF, AW'(45));
    pol3_i = 1'b1;
    cyc(1'b0, 1'b1, 8'hFF, AW'(46));
    ce2_i = 1'b1; pol2_i = 1'b1; ce3_i = 1'b0; pol3_i = 1'b0;
    cyc(1'b0, 1'b1, 8'hFF, AW'(44));
    idle(3);

    cur_tag = "R11 R9 R5 random";
    for (int i = 0; i < 4000; i++) begin
      logic adv;
      adv = ($urandom_range(0, 2) != 0);
      if (i == 2000 || i == 0) adv = 1'b0;
      if (!adv) begin
        if (i == 2000) burst_mode_i = 1'b1;
        ce_ni = ($urandom_range(0, 7) == 0);
        ce2_i = ($urandom_range(0, 15) == 0) ? ~pol2_i : pol2_i;
      end
      cyc(adv, $urandom_range(0, 1) == 1, 8'($urandom()), AW'($urandom()));
    end
    ce2_i = pol2_i;
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule